// File: doc/BRIEF.md
# SD Host Command and Status Unit

This block sits between a register interface and a card-side command engine. Software writes a 32-bit argument as two halves and then writes a command word. The unit decodes the command word and hands the index, command type, direction and argument to the card side with a one-cycle request strobe. It then waits, with a busy flag raised, until the card side reports completion. Completion carries a byte count and up to sixteen response bytes.

When a response completes, the unit checks the byte count against the response format and flags a timeout if the count is too short. It checks the card status word for error bits that depend on the response type. It packs the bytes into eight 16-bit response registers and sets the matching bits in a 16-bit event status register. A 15-bit enable mask gates the status bits onto a single level interrupt. A rising edge on the card-detect input also records an event. Software clears status bits by writing ones to them.

Top module: `sdh_cmd_stat`

## Requirements
- R1: The command word is decoded as follows: bits 5:0 are the index, bit 7 is the init flag, bits 10:8 are the response type, bit 11 is the busy flag, bits 13:12 are the command type and bit 15 is the direction. When a command is launched, `cmd_req_o` is high for exactly the one cycle after the accepting edge. During that cycle `cmd_idx_o`, `cmd_type_o`, `cmd_dir_o` and `cmd_arg_o` carry the decoded fields and the argument.
- R2: A command write is ignored while the enable bit (address 3, bit 0) is clear, and also while `busy_o` is high. An ignored write raises no request and does not change the stored command, the status register or the response registers.
- R3: An accepted command write clears all eight response registers at the accepting edge.
- R4: If the init flag is set and the index is 0, status bit 0 is set at the accepting edge. No request is raised and `busy_o` stays low.
- R5: Response types 1, 3 and 6 need at least 4 bytes, and type 2 needs at least 16 bytes. A completion with fewer bytes is a timeout: status bit 7 is set, bit 0 is not set, and the response registers stay cleared.
- R6: A completion that is not a timeout sets status bit 0. If the index is 12, it also sets status bit 2. Response type 0, and the unused codes 4, 5 and 7, complete without a length check and without packing.
- R7: The card status word is {byte0, byte1, byte2, byte3}. For type 1, any bit of the word under 0xFDF90000 sets status bit 14. For type 6, any bit of the low 16 bits under 0xE008 sets status bit 14. Types 2 and 3 never set bit 14.
- R8: On a non-timeout completion of types 1, 2, 3 or 6, response register 7-j (addresses 8 to 15 hold registers 0 to 7) receives {byte 2j, byte 2j+1}. Byte k is `rsp_bytes_i[8k+7:8k]`.
- R9: `irq_o` is high exactly when the AND of status and the enable mask is nonzero. A mask write (address 5) keeps only bits 14:0.
- R10: Writing the status register (address 4) clears each bit written as 1. An event that sets a bit in the same cycle wins over the clear.
- R11: A rising edge on `card_det_i`, seen between two consecutive clock edges, sets status bit 1.
- R12: Address 1 writes argument bits 15:0 and address 2 writes bits 31:16. Each write leaves the other half unchanged, and both halves read back.
- R13: `busy_o` is high from the cycle after a launching write until the edge at which `rsp_done_i` is sampled high. A `rsp_done_i` pulse while the unit is not busy has no effect.
- R14: After reset, every register reads 0, and `irq_o`, `busy_o` and `cmd_req_o` are low. Address 0 reads the last accepted command, address 3 reads the enable bit, and addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| cmd_req_o | output | 1 | One-cycle command launch strobe |
| cmd_idx_o | output | 6 | Command index |
| cmd_arg_o | output | 32 | Command argument |
| cmd_type_o | output | 2 | Command type field |
| cmd_dir_o | output | 1 | Data direction field |
| busy_o | output | 1 | Waiting for a response |
| rsp_done_i | input | 1 | Response completion from the card side |
| rsp_len_i | input | 5 | Number of response bytes returned |
| rsp_bytes_i | input | 128 | Response bytes, byte k at bits 8k+7:8k |
| card_det_i | input | 1 | Card-detect level |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the unit with its default of eight response registers. With that default, the long format needs sixteen bytes, so a 15-byte completion sits exactly on the timeout boundary. All of the reverse pair order can be seen across addresses 8 to 15. The bench reaches the short and long timeouts, the per-type error masks, the stop-index bit, and a status clear that collides with a card-detect edge. It also drives a command while busy and a completion while idle.

// File: rtl/sdh_pkg.sv
package sdh_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned REG_W  = 16;

  localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
  localparam logic [ADDR_W-1:0] A_ARG_LO = 4'd1;
  localparam logic [ADDR_W-1:0] A_ARG_HI = 4'd2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd4;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'd5;
  localparam int unsigned       RSP_BASE = 8;

  localparam int unsigned ST_DONE = 0;
  localparam int unsigned ST_CDET = 1;
  localparam int unsigned ST_STOP = 2;
  localparam int unsigned ST_TMO  = 7;
  localparam int unsigned ST_CERR = 14;

  localparam logic [2:0] RT_NONE = 3'd0;
  localparam logic [2:0] RT_STD  = 3'd1;
  localparam logic [2:0] RT_LONG = 3'd2;
  localparam logic [2:0] RT_OCR  = 3'd3;
  localparam logic [2:0] RT_ADDR = 3'd6;

  localparam logic [31:0] STD_ERR_BITS  = 32'hFDF9_0000;
  localparam logic [15:0] ADDR_ERR_BITS = 16'hE008;
  localparam int unsigned SHORT_BYTES   = 4;

  typedef struct packed {
    logic       dir;
    logic       rsvd14;
    logic [1:0] ctype;
    logic       busy;
    logic [2:0] rtype;
    logic       init;
    logic       rsvd6;
    logic [5:0] idx;
  } cmd_word_t;
endpackage

// File: rtl/sdh_cmd_ctl.sv
module sdh_cmd_ctl
  import sdh_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rsp_done_i,
  output logic              en_o,
  output logic [31:0]       arg_o,
  output cmd_word_t         cmd_o,
  output logic              busy_o,
  output logic              req_o,
  output logic              accept_o,
  output logic              init_hit_o,
  output logic              done_o
);
  cmd_word_t wr_cmd;
  logic      cmd_wr, launch;
  logic      en_q, busy_q, req_q;
  logic [31:0] arg_q;
  cmd_word_t cmd_q;

  assign wr_cmd     = cmd_word_t'(wr_data_i);
  assign cmd_wr     = wr_en_i && (wr_addr_i == A_CMD);
  assign accept_o   = cmd_wr && en_q && !busy_q;
  assign init_hit_o = accept_o && wr_cmd.init && (wr_cmd.idx == '0);
  assign launch     = accept_o && !init_hit_o;
  assign done_o     = busy_q && rsp_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      arg_q  <= '0;
      cmd_q  <= '0;
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= launch;
      if (wr_en_i && wr_addr_i == A_CTRL)   en_q <= wr_data_i[0];
      if (wr_en_i && wr_addr_i == A_ARG_LO) arg_q[15:0]  <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_ARG_HI) arg_q[31:16] <= wr_data_i;
      if (accept_o) cmd_q <= wr_cmd;
      if (launch)      busy_q <= 1'b1;
      else if (done_o) busy_q <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign arg_o  = arg_q;
  assign cmd_o  = cmd_q;
  assign busy_o = busy_q;
  assign req_o  = req_q;

  // R1: a launch strobes the request on the next cycle
  p_req_follows_launch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && en_q && !busy_q && !(wr_cmd.init && wr_cmd.idx == '0)) |=> (req_o && busy_o));
  // R2: a write while disabled changes nothing on the card side
  p_disabled_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !en_q && !busy_q) |=> (!req_o && !busy_o && $stable(cmd_q)));
  // R13: completion drops busy
  p_done_releases_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rsp_done_i) |=> !busy_o);
  // R4: init with index 0 never launches
  p_init_no_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && en_q && !busy_q && wr_cmd.init && wr_cmd.idx == '0) |=> !req_o);
endmodule

// File: rtl/sdh_rsp_eval.sv
module sdh_rsp_eval
  import sdh_pkg::*;
#(
  parameter int unsigned LONG_BYTES = 16,
  parameter int unsigned STOP_IDX   = 12,
  localparam int unsigned LEN_W     = $clog2(LONG_BYTES + 1)
) (
  input  logic [2:0]       rtype_i,
  input  logic [5:0]       idx_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [31:0]      head_i,
  output logic [REG_W-1:0] set_o,
  output logic             tmo_o,
  output logic             load_o
);
  logic        is_short, is_long, err;
  logic [31:0] word;

  // card status word: byte0 is most significant
  assign word     = {head_i[7:0], head_i[15:8], head_i[23:16], head_i[31:24]};
  assign is_short = (rtype_i == RT_STD) || (rtype_i == RT_OCR) || (rtype_i == RT_ADDR);
  assign is_long  = (rtype_i == RT_LONG);
  assign tmo_o    = (is_short && len_i < LEN_W'(SHORT_BYTES)) ||
                    (is_long  && len_i < LEN_W'(LONG_BYTES));
  assign err      = ((rtype_i == RT_STD)  && |(word & STD_ERR_BITS)) ||
                    ((rtype_i == RT_ADDR) && |(word[15:0] & ADDR_ERR_BITS));
  assign load_o   = !tmo_o && (is_short || is_long);

  always_comb begin
    set_o = '0;
    if (tmo_o) begin
      set_o[ST_TMO] = 1'b1;
    end else begin
      set_o[ST_DONE] = 1'b1;
      set_o[ST_STOP] = (idx_i == 6'(STOP_IDX));
      set_o[ST_CERR] = err;
    end
  end
endmodule

// File: rtl/sdh_rsp_bank.sv
module sdh_rsp_bank
  import sdh_pkg::*;
#(
  parameter int unsigned N_REGS = 8,
  localparam int unsigned N_BYTES = 2 * N_REGS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    load_i,
  input  logic [8*N_BYTES-1:0]    bytes_i,
  output logic [REG_W*N_REGS-1:0] rsp_o
);
  for (genvar r = 0; r < N_REGS; r++) begin : g_reg
    localparam int unsigned PAIR = N_REGS - 1 - r;
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q <= '0;
      else if (clr_i)  q <= '0;
      else if (load_i) q <= {bytes_i[16*PAIR +: 8], bytes_i[16*PAIR+8 +: 8]};
    end
    assign rsp_o[REG_W*r +: REG_W] = q;
  end

  // R3: clearing and loading come from disjoint phases of a command
  p_clr_load_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_i && load_i));
  // R3: a clear leaves every register at zero
  p_clear_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rsp_o == '0));
endmodule

// File: rtl/sdh_stat_irq.sv
module sdh_stat_irq
  import sdh_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stat_i,
  input  logic             wr_mask_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [REG_W-1:0] set_i,
  input  logic             cdet_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o
);
  logic [REG_W-1:0] status_q, clr, rise_set;
  logic [REG_W-2:0] mask_q;
  logic             cdet_q;

  assign clr      = wr_stat_i ? wr_data_i : '0;
  assign rise_set = REG_W'(cdet_i && !cdet_q) << ST_CDET;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
      cdet_q   <= 1'b0;
    end else begin
      cdet_q   <= cdet_i;
      status_q <= (status_q & ~clr) | set_i | rise_set;
      if (wr_mask_i) mask_q <= wr_data_i[REG_W-2:0];
    end
  end

  assign status_o = status_q;
  assign mask_o   = {1'b0, mask_q};
  assign irq_o    = |(status_q[REG_W-2:0] & mask_q);

  // R10: written ones are gone unless an event sets them again
  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && set_i == '0 && !(cdet_i && !cdet_q)) |=> ((status_q & $past(wr_data_i)) == '0));
  // R11: a card-detect edge is recorded even against a clear
  p_cdet_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdet_i && !cdet_q) |=> status_q[ST_CDET]);
  // R9: the top mask bit never stores
  p_mask_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_i |=> (mask_o[REG_W-1] == 1'b0 && mask_o[REG_W-2:0] == $past(wr_data_i[REG_W-2:0])));
endmodule

// File: rtl/sdh_cmd_stat.sv
module sdh_cmd_stat
  import sdh_pkg::*;
#(
  parameter int unsigned N_RSP_REGS = 8,
  parameter int unsigned STOP_IDX   = 12,
  localparam int unsigned N_BYTES   = 2 * N_RSP_REGS,
  localparam int unsigned LEN_W     = $clog2(N_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [REG_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [REG_W-1:0]   rd_data_o,
  output logic               cmd_req_o,
  output logic [5:0]         cmd_idx_o,
  output logic [31:0]        cmd_arg_o,
  output logic [1:0]         cmd_type_o,
  output logic               cmd_dir_o,
  output logic               busy_o,
  input  logic               rsp_done_i,
  input  logic [LEN_W-1:0]   rsp_len_i,
  input  logic [8*N_BYTES-1:0] rsp_bytes_i,
  input  logic               card_det_i,
  output logic               irq_o
);
  logic             en, accept, init_hit, done, tmo, load;
  logic [31:0]      arg;
  cmd_word_t        cmd;
  logic [REG_W-1:0] eval_set, set, status, mask;
  logic [REG_W*N_RSP_REGS-1:0] rsp_flat;
  logic             unused_cmd_bits;

  sdh_cmd_ctl u_ctl (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rsp_done_i,
    .en_o(en), .arg_o(arg), .cmd_o(cmd), .busy_o, .req_o(cmd_req_o),
    .accept_o(accept), .init_hit_o(init_hit), .done_o(done)
  );

  sdh_rsp_eval #(.LONG_BYTES(N_BYTES), .STOP_IDX(STOP_IDX)) u_eval (
    .rtype_i(cmd.rtype), .idx_i(cmd.idx), .len_i(rsp_len_i), .head_i(rsp_bytes_i[31:0]),
    .set_o(eval_set), .tmo_o(tmo), .load_o(load)
  );

  sdh_rsp_bank #(.N_REGS(N_RSP_REGS)) u_bank (
    .clk_i, .rst_ni, .clr_i(accept), .load_i(done && load),
    .bytes_i(rsp_bytes_i), .rsp_o(rsp_flat)
  );

  assign set = (init_hit ? REG_W'(1) << ST_DONE : '0) | (done ? eval_set : '0);

  sdh_stat_irq u_stat (
    .clk_i, .rst_ni,
    .wr_stat_i(wr_en_i && wr_addr_i == A_STAT),
    .wr_mask_i(wr_en_i && wr_addr_i == A_MASK),
    .wr_data_i, .set_i(set), .cdet_i(card_det_i),
    .status_o(status), .mask_o(mask), .irq_o
  );

  assign cmd_idx_o       = cmd.idx;
  assign cmd_type_o      = cmd.ctype;
  assign cmd_dir_o       = cmd.dir;
  assign cmd_arg_o       = arg;
  assign unused_cmd_bits = ^{cmd.busy, cmd.init, cmd.rsvd6, cmd.rsvd14};

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CMD:    rd_data_o = REG_W'(cmd);
      A_ARG_LO: rd_data_o = arg[15:0];
      A_ARG_HI: rd_data_o = arg[31:16];
      A_CTRL:   rd_data_o = REG_W'(en);
      A_STAT:   rd_data_o = status;
      A_MASK:   rd_data_o = mask;
      default: begin
        for (int r = 0; r < N_RSP_REGS; r++)
          if (rd_addr_i == ADDR_W'(RSP_BASE + r)) rd_data_o = rsp_flat[REG_W*r +: REG_W];
      end
    endcase
  end

  // R5: a short completion flags timeout and leaves responses cleared
  p_timeout_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && tmo) |=> (status[ST_TMO] && rsp_flat == '0));
  // R6: stop index adds the extra completion bit
  p_stop_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !tmo && cmd.idx == 6'(STOP_IDX)) |=> (status[ST_DONE] && status[ST_STOP]));
  // R13: a completion while idle leaves responses alone
  p_idle_done_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_i && !busy_o && !wr_en_i) |=> $stable(rsp_flat));
endmodule

// File: tb/sdh_cmd_stat_bench.sv
`timescale 1ns/100ps
module sdh_cmd_stat_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic         wr_en = 0;
  logic [3:0]   wr_addr = 0, rd_addr = 0;
  logic [15:0]  wr_data = 0, rd_data;
  logic         cmd_req, cmd_dir, busy, irq;
  logic [5:0]   cmd_idx;
  logic [31:0]  cmd_arg;
  logic [1:0]   cmd_type;
  logic         rsp_done = 0, cdet = 0;
  logic [4:0]   rsp_len = 0;
  logic [127:0] rsp_bytes = '0;

  sdh_cmd_stat u_sdh_cmd_stat (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cmd_req_o(cmd_req), .cmd_idx_o(cmd_idx),
    .cmd_arg_o(cmd_arg), .cmd_type_o(cmd_type), .cmd_dir_o(cmd_dir), .busy_o(busy),
    .rsp_done_i(rsp_done), .rsp_len_i(rsp_len), .rsp_bytes_i(rsp_bytes),
    .card_det_i(cdet), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit          m_en, m_busy, m_req, m_cd;
  logic [31:0] m_arg;
  logic [15:0] m_last, m_stat, m_mask, sets, clr;
  logic [15:0] m_rsp [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_busy = 0; m_req = 0; m_cd = 0; m_arg = 0;
      m_last = 0; m_stat = 0; m_mask = 0;
      foreach (m_rsp[i]) m_rsp[i] = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      sets = 0; clr = 0; m_req = 0;
      if (wr_en) begin
        case (wr_addr)
          0: if (m_en && !was_busy) begin
               m_last = wr_data;
               foreach (m_rsp[i]) m_rsp[i] = 0;
               if (wr_data[7] && wr_data[5:0] == 0) sets |= 16'h0001;
               else begin m_busy = 1; m_req = 1; end
             end
          1: m_arg[15:0]  = wr_data;
          2: m_arg[31:16] = wr_data;
          3: m_en = wr_data[0];
          4: clr = wr_data;
          5: m_mask = wr_data & 16'h7fff;
          default: ;
        endcase
      end
      if (rsp_done && was_busy) begin
        int t, need;
        logic [31:0] word;
        t = int'(m_last[10:8]);
        need = (t == 2) ? 16 : (t == 1 || t == 3 || t == 6) ? 4 : 0;
        word = {rsp_bytes[7:0], rsp_bytes[15:8], rsp_bytes[23:16], rsp_bytes[31:24]};
        if (need != 0 && int'(rsp_len) < need) sets |= 16'h0080;
        else begin
          sets |= 16'h0001;
          if (m_last[5:0] == 12) sets |= 16'h0004;
          if (t == 1 && (word & 32'hFDF90000) != 0) sets |= 16'h4000;
          if (t == 6 && (word[15:0] & 16'hE008) != 0) sets |= 16'h4000;
          if (need != 0)
            for (int j = 0; j < 8; j++)
              m_rsp[7-j] = {rsp_bytes[16*j +: 8], rsp_bytes[16*j+8 +: 8]};
        end
        m_busy = 0;
      end
      if (cdet && !m_cd) sets |= 16'h0002;
      m_cd = cdet;
      m_stat = (m_stat & ~clr) | sets;
    end
  end

  function automatic logic [15:0] m_read(int a);
    case (a)
      0: return m_last;
      1: return m_arg[15:0];
      2: return m_arg[31:16];
      3: return {15'd0, m_en};
      4: return m_stat;
      5: return m_mask;
      6, 7: return 16'h0;
      default: return m_rsp[a-8];
    endcase
  endfunction

  // per-cycle output comparison
  always @(negedge clk) if (rst_n) begin
    chk("R9 irq", irq, (m_stat & m_mask) != 0);
    chk("R13 busy", busy, m_busy);
    chk("R1 req", cmd_req, m_req);
    if (m_req) begin
      chk("R1 idx", cmd_idx, m_last[5:0]);
      chk("R1 type", cmd_type, m_last[13:12]);
      chk("R1 dir", cmd_dir, m_last[15]);
      chk("R1 arg", cmd_arg, m_arg);
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic respond(int len, logic [127:0] b);
    @(negedge clk); rsp_done = 1; rsp_len = 5'(len); rsp_bytes = b;
    @(negedge clk); rsp_done = 0;
  endtask

  task automatic dump(string tag);
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); rd_addr = 4'(a); #1;
      chk(tag, rd_data, m_read(a));
    end
  endtask

  function automatic logic [127:0] ramp(int base);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) v[8*k +: 8] = 8'(base + k);
    return v;
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    dump("R14 reset state");
    wr(0, 16'h0111);                        // enable still clear
    dump("R2 disabled command ignored");
    wr(3, 16'h0001);
    wr(1, 16'hBEEF); wr(2, 16'h1234);
    dump("R12 argument halves");
    wr(1, 16'h5678);
    dump("R12 low half only");
    wr(5, 16'hFFFF);
    dump("R9 mask keeps 14:0");
    wr(0, 16'h0080);                        // init, index 0
    dump("R4 init command");
    wr(4, 16'hFFFF);
    dump("R10 write-one clear");
    wr(0, 16'h0202);                        // type 2 long
    wr(0, 16'h0303);                        // while busy
    dump("R2 command while busy");
    respond(16, ramp(8'h10));
    dump("R8 long packing");
    wr(0, 16'h0111);
    dump("R3 clear on accept");
    respond(4, 128'h0009_0000);             // b2=0x09: no error bits
    dump("R6 R8 short response");
    wr(4, 16'hFFFF);
    wr(0, 16'h090C);                        // index 12, type 1 with busy flag
    respond(4, 128'h80);                    // b0=0x80 error
    dump("R6 R7 stop with card error");
    wr(4, 16'hFFFF);
    wr(0, 16'h0203);
    respond(15, ramp(8'h40));
    dump("R5 long timeout at 15 bytes");
    wr(0, 16'h0105);
    respond(3, ramp(8'h50));
    dump("R5 short timeout");
    wr(4, 16'hFFFF);
    wr(0, 16'h0603);
    respond(4, 128'h0020_0000);            // b2=0x20
    dump("R7 type 6 error");
    wr(4, 16'hFFFF);
    wr(0, 16'h0301);
    respond(4, 128'hFFFF_FFFF);
    dump("R7 type 3 no error");
    wr(0, 16'h0000);                        // no response type
    respond(0, '0);
    dump("R6 no-response completion");
    respond(16, ramp(8'h70));
    dump("R13 idle completion ignored");
    wr(4, 16'hFFFF);
    @(negedge clk); cdet = 1;
    repeat (2) @(negedge clk);
    dump("R11 card detect edge");
    cdet = 0;
    @(negedge clk);
    cdet = 1; wr_en = 1; wr_addr = 4; wr_data = 16'hFFFF;
    @(negedge clk); wr_en = 0;
    dump("R10 set wins over clear");
    wr(0, 16'hB105);                        // dir, type 3 field, index 5
    respond(4, 128'h1);
    dump("R1 decoded fields");
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule